// File: doc/BRIEF.md
# Duty-Skewed Waveform Table Generator

This block fills a sample memory with one period of a test waveform. A start pulse captures a configuration: a wave shape (half-sine pair, square, triangle or sawtooth), a duty percentage, an amplitude code, an offset code, and a lower and an upper clamp code. The duty percentage places a split index inside a 128-sample period. The first segment runs from index 0 up to the split and the second segment fills the rest. Each segment is stretched on its own, so a duty other than 50 gives an asymmetric wave.

After a short setup phase, the block writes one 32-bit word per clock to a RAM write port, at addresses 0 through 128. Address 128 always holds the clamped offset level, so a player that stops after the last entry leaves the output at rest. A one-cycle `done` pulse follows the last write.

In setup, a shared sequential divider computes two step sizes, one for each segment. During the fill, an accumulator of quotient and remainder reproduces exact truncated ratios without any per-sample division.

Top module: `sg_wavetable_gen`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low.
- R2: With `dc = min(duty_pct,100)`, the split index is `D = floor(dc*128/100)` and the half amplitude is `H = floor(amplitude/2)`. For an index x below D the segment is the first one, with local position `t = x` and length `L = D`. Otherwise `t = x-D` and `L = 128-D`.
- R3: Shape code 0 is a half-sine pair built as a parabola. With `p = floor(256*t/L)` and `m = floor(H*p*(256-p)/16384)`, the value is `offset+m` in the first segment and `offset-m` in the second.
- R4: Shape code 1 is a square wave: `offset+H` in the first segment and `offset-H` in the second.
- R5: Shape code 2 is a triangle. With `g = |floor(2*H*t/L) - H|`, the value is `offset+H-g` in the first segment and `offset-H+g` in the second.
- R6: Shape code 3 is a sawtooth: `offset-H+floor(H*t/L)` in the first segment and `offset+floor(H*t/L)` in the second.
- R7: Each value is clamped. A value below `lim_lo` becomes `lim_lo`. Otherwise a value above `lim_hi` becomes `lim_hi`.
- R8: Writes go to addresses 0 to 128 in ascending order on consecutive cycles. Address 128 holds the clamped offset.
- R9: The word holds the 10-bit clamped code in bits 15:6. Bits 31:16 and 5:0 are zero.
- R10: A split of 0 (all samples in the second segment) or 128 (all samples in the first segment) produces a full period with no division by zero.
- R11: While `busy` is high, a start pulse and any change of the configuration inputs have no effect on the running fill.
- R12: Shape codes 4 to 7 make no writes and still give a `done` pulse.
- R13: `done` is high for one cycle, directly after the last write, and `busy` is low on the next cycle. The first write comes no more than 32 cycles after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a fill |
| mode | input | 3 | Shape code |
| duty_pct | input | 7 | Duty percentage; values above 100 act as 100 |
| amplitude | input | 10 | Peak-to-peak amplitude code |
| offset | input | 10 | Centre level code |
| lim_lo | input | 10 | Lower clamp code |
| lim_hi | input | 10 | Upper clamp code |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Sample memory write enable |
| wr_addr | output | 8 | Sample memory write address |
| wr_data | output | 32 | Formatted sample word |

## Verification
The setup phase is the only part whose length the block is free to choose. For that reason, the bench pins down only the start-to-first-write latency, as a bound of 32 cycles. It then requires every later write on the clock right after the previous one, and `done` exactly one clock after address 128. On every clock between edges, a behavioural model holds a queue of the 129 expected words and compares each write against the head of that queue. It also checks that `done` arrives with the queue empty and that `busy` drops on the following clock.

// File: rtl/sg_pkg.sv
`timescale 1ns/1ps
package sg_pkg;
    localparam int SAMPLES  = 128;
    localparam int IDX_W    = $clog2(SAMPLES) + 1;
    localparam int LEN_W    = IDX_W;
    localparam int CODE_W   = 10;
    localparam int DUTY_W   = 7;
    localparam int WORD_W   = 32;
    localparam int CODE_LSB = 6;
    localparam int PH_W     = 8;
    localparam int NUM_W    = CODE_W;
    localparam int Q_W      = NUM_W + 1;
    localparam int VAL_W    = CODE_W + 3;

    localparam logic [2:0] SHAPE_SINE = 3'd0;
    localparam logic [2:0] SHAPE_SQR  = 3'd1;
    localparam logic [2:0] SHAPE_TRI  = 3'd2;
    localparam logic [2:0] SHAPE_SAW  = 3'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_DIV_A, S_DIV_B, S_FILL, S_DONE
    } fill_state_e;

    typedef struct packed {
        logic [2:0]        shape;
        logic [CODE_W-2:0] half;
        logic [CODE_W-1:0] level;
        logic [CODE_W-1:0] floor_c;
        logic [CODE_W-1:0] ceil_c;
        logic [LEN_W-1:0]  split;
    } fill_cfg_t;

    function automatic logic [LEN_W-1:0] split_of(input logic [DUTY_W-1:0] duty);
        int unsigned dc;
        dc = (duty > DUTY_W'(100)) ? 100 : int'(duty);
        return LEN_W'((dc * SAMPLES) / 100);
    endfunction

    function automatic logic [CODE_W-1:0] clamp_code(input logic signed [VAL_W-1:0] v,
                                                     input logic [CODE_W-1:0] lo,
                                                     input logic [CODE_W-1:0] hi);
        logic signed [VAL_W-1:0] lo_s, hi_s, r;
        lo_s = $signed(VAL_W'(lo));
        hi_s = $signed(VAL_W'(hi));
        if (v < lo_s)      r = lo_s;
        else if (v > hi_s) r = hi_s;
        else               r = v;
        return r[CODE_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] code);
        return WORD_W'({code, {CODE_LSB{1'b0}}});
    endfunction
endpackage

// File: rtl/sg_divider.sv
`timescale 1ns/1ps
module sg_divider #(
    parameter int NUM_W = 10,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [NUM_W-1:0] quo_q, num_q;
    logic [DEN_W-1:0] rem_q, den_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            quo_q  <= '0;
            num_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                cnt_q <= CNT_W'(NUM_W);
                rem_q <= '0;
                quo_q <= num;
                num_q <= num;
                den_q <= den;
            end else if (cnt_q != '0) begin
                rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    logic [NUM_W+DEN_W-1:0] recon;
    assign recon = (NUM_W+DEN_W)'(quo_q) * (NUM_W+DEN_W)'(den_q) + (NUM_W+DEN_W)'(rem_q);

    p_div_exact_r2: assert property (@(posedge clk) disable iff (rst)
        (done_q && den_q != '0) |-> (recon == (NUM_W+DEN_W)'(num_q) && rem_q < den_q));
endmodule

// File: rtl/sg_seg_accum.sv
`timescale 1ns/1ps
module sg_seg_accum #(
    parameter int Q_W    = 11,
    parameter int STEP_W = 10,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [STEP_W-1:0] qs,
    input  logic [LEN_W-1:0]  rs,
    input  logic [LEN_W-1:0]  len,
    output logic [Q_W-1:0]    q
);
    logic [Q_W-1:0]   q_q;
    logic [LEN_W-1:0] r_q;
    logic [LEN_W:0]   r_sum;
    logic             wrap;

    assign r_sum = {1'b0, r_q} + {1'b0, rs};
    assign wrap  = r_sum >= {1'b0, len};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q_q <= '0;
            r_q <= '0;
        end else if (step) begin
            r_q <= wrap ? LEN_W'(r_sum - {1'b0, len}) : r_sum[LEN_W-1:0];
            q_q <= q_q + Q_W'(qs) + Q_W'(wrap);
        end
    end

    assign q = q_q;

    p_rem_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (step && len != '0) |-> (r_q < len));
endmodule

// File: rtl/sg_shape.sv
`timescale 1ns/1ps
module sg_shape
    import sg_pkg::*;
(
    input  logic [2:0]              shape,
    input  logic                    second,
    input  logic [Q_W-1:0]          q,
    input  logic [CODE_W-2:0]       half,
    input  logic [CODE_W-1:0]       level,
    output logic signed [VAL_W-1:0] value
);
    localparam int PROD_W = (CODE_W - 1) + 2 * (PH_W + 1);

    logic signed [VAL_W-1:0] lvl_s, half_s, q_s, g_s, g_abs, mag_s;
    logic [PH_W:0]           ph, comp;
    logic [PROD_W-1:0]       prod;

    always_comb begin
        lvl_s  = $signed(VAL_W'(level));
        half_s = $signed(VAL_W'(half));
        q_s    = $signed(VAL_W'(q));
        ph     = q[PH_W:0];
        comp   = (PH_W+1)'(1 << PH_W) - ph;
        prod   = PROD_W'(half) * PROD_W'(ph) * PROD_W'(comp);
        mag_s  = $signed(VAL_W'(prod >> (2 * PH_W - 2)));
        g_s    = q_s - half_s;
        g_abs  = (g_s < 0) ? -g_s : g_s;
        case (shape)
            SHAPE_SINE: value = second ? lvl_s - mag_s : lvl_s + mag_s;
            SHAPE_SQR:  value = second ? lvl_s - half_s : lvl_s + half_s;
            SHAPE_TRI:  value = second ? lvl_s - half_s + g_abs : lvl_s + half_s - g_abs;
            default:    value = second ? lvl_s + q_s : lvl_s - half_s + q_s;
        endcase
    end
endmodule

// File: rtl/sg_wavetable_gen.sv
`timescale 1ns/1ps
module sg_wavetable_gen
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DUTY_W-1:0] duty_pct,
    input  logic [CODE_W-1:0] amplitude,
    input  logic [CODE_W-1:0] offset,
    input  logic [CODE_W-1:0] lim_lo,
    input  logic [CODE_W-1:0] lim_hi,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    fill_state_e      state_q;
    fill_cfg_t        cfg_q;
    logic [IDX_W-1:0] idx_q;
    logic [NUM_W-1:0] qa_q, qb_q;
    logic [LEN_W-1:0] ra_q, rb_q;

    logic [LEN_W-1:0] len_b;
    logic             shape_ok, second, div_start, div_done, acc_clear, acc_step;
    logic [NUM_W-1:0] numer, div_q;
    logic [LEN_W-1:0] div_r, div_den;
    logic [Q_W-1:0]   acc_q;
    logic signed [VAL_W-1:0] shape_val, pick_val;
    logic [CODE_W-1:0] code;

    assign len_b    = LEN_W'(SAMPLES) - cfg_q.split;
    assign shape_ok = cfg_q.shape <= SHAPE_SAW;
    assign second   = idx_q >= IDX_W'(cfg_q.split);

    always_comb begin
        case (cfg_q.shape)
            SHAPE_SINE: numer = NUM_W'(1 << PH_W);
            SHAPE_TRI:  numer = {cfg_q.half, 1'b0};
            SHAPE_SAW:  numer = NUM_W'(cfg_q.half);
            default:    numer = '0;
        endcase
    end

    assign div_start = (state_q == S_SETUP && shape_ok) || (state_q == S_DIV_A && div_done);
    assign div_den   = (state_q == S_SETUP) ? cfg_q.split : len_b;

    sg_divider #(.NUM_W(NUM_W), .DEN_W(LEN_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(numer), .den(div_den),
        .done(div_done), .quo(div_q), .rem(div_r)
    );

    assign acc_clear = (state_q == S_DIV_B && div_done) ||
                       (state_q == S_FILL && (idx_q + 1'b1) == IDX_W'(cfg_q.split));
    assign acc_step  = (state_q == S_FILL) && !acc_clear && (idx_q < IDX_W'(SAMPLES));

    sg_seg_accum #(.Q_W(Q_W), .STEP_W(NUM_W), .LEN_W(LEN_W)) u_acc (
        .clk(clk), .rst(rst), .clear(acc_clear), .step(acc_step),
        .qs(second ? qb_q : qa_q), .rs(second ? rb_q : ra_q),
        .len(second ? len_b : cfg_q.split), .q(acc_q)
    );

    sg_shape u_shape (
        .shape(cfg_q.shape), .second(second), .q(acc_q), .half(cfg_q.half),
        .level(cfg_q.level), .value(shape_val)
    );

    assign pick_val = (idx_q == IDX_W'(SAMPLES)) ? $signed(VAL_W'(cfg_q.level)) : shape_val;
    assign code     = clamp_code(pick_val, cfg_q.floor_c, cfg_q.ceil_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            qa_q    <= '0;
            qb_q    <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    cfg_q.shape   <= mode;
                    cfg_q.half    <= amplitude[CODE_W-1:1];
                    cfg_q.level   <= offset;
                    cfg_q.floor_c <= lim_lo;
                    cfg_q.ceil_c  <= lim_hi;
                    cfg_q.split   <= split_of(duty_pct);
                    state_q       <= S_SETUP;
                end
                S_SETUP: state_q <= shape_ok ? S_DIV_A : S_DONE;
                S_DIV_A: if (div_done) begin
                    qa_q    <= (cfg_q.split == '0) ? '0 : div_q;
                    ra_q    <= (cfg_q.split == '0) ? '0 : div_r;
                    state_q <= S_DIV_B;
                end
                S_DIV_B: if (div_done) begin
                    qb_q    <= (len_b == '0) ? '0 : div_q;
                    rb_q    <= (len_b == '0) ? '0 : div_r;
                    idx_q   <= '0;
                    state_q <= S_FILL;
                end
                S_FILL: begin
                    if (idx_q == IDX_W'(SAMPLES)) state_q <= S_DONE;
                    else                          idx_q   <= idx_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy    = state_q != S_IDLE;
    assign done    = state_q == S_DONE;
    assign wr_en   = state_q == S_FILL;
    assign wr_addr = idx_q;
    assign wr_data = pack_word(code);

    p_first_addr_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> wr_addr == '0);
    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);
    p_format_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data[CODE_LSB-1:0] == '0 && wr_data[WORD_W-1:CODE_LSB+CODE_W] == '0));
    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_q.floor_c <= cfg_q.ceil_c) |->
        (wr_data[CODE_LSB+:CODE_W] >= cfg_q.floor_c && wr_data[CODE_LSB+:CODE_W] <= cfg_q.ceil_c));
    p_cfg_held_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(cfg_q));
    p_done_after_fill_r13: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en) |-> done);
    p_done_short_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

// File: tb/sg_wavetable_gen_tb.sv
`timescale 1ns/1ps
module sg_wavetable_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [6:0]  duty_pct = '0;
    logic [9:0]  amplitude = '0, offset = '0, lim_lo = '0, lim_hi = '0;
    logic        busy, done, wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sg_wavetable_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .duty_pct(duty_pct),
        .amplitude(amplitude), .offset(offset), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_word(int m, int duty, int amp, int off, int lo, int hi, int x);
        int dc, d, e, h, t, l, p, mg, g, v;
        bit s0;
        dc = (duty > 100) ? 100 : duty;
        d = dc * 128 / 100;
        e = 128 - d;
        h = amp / 2;
        if (x == 128) v = off;
        else begin
            s0 = x < d;
            t = s0 ? x : x - d;
            l = s0 ? d : e;
            case (m)
                0: begin
                    p = 256 * t / l;
                    mg = h * p * (256 - p) / 16384;
                    v = s0 ? off + mg : off - mg;
                end
                1: v = s0 ? off + h : off - h;
                2: begin
                    g = (2 * h * t) / l - h;
                    if (g < 0) g = -g;
                    v = s0 ? off + h - g : off - h + g;
                end
                default: v = s0 ? off - h + (h * t) / l : off + (h * t) / l;
            endcase
        end
        if (v < lo) v = lo;
        else if (v > hi) v = hi;
        return v << 6;
    endfunction

    task automatic run_case(input string tag, input int m, input int duty, input int amp,
                            input int off, input int lo, input int hi, input bit restart);
        int exp_q[$];
        int cyc, first, nwr, last_wr;
        bit seen_done;
        if (m <= 3) for (int x = 0; x <= 128; x++) exp_q.push_back(exp_word(m, duty, amp, off, lo, hi, x));
        @(negedge clk);
        mode = 3'(m); duty_pct = 7'(duty); amplitude = 10'(amp);
        offset = 10'(off); lim_lo = 10'(lo); lim_hi = 10'(hi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first = -1; nwr = 0; last_wr = -10; seen_done = 0;
        for (int c = 1; c <= 400 && !seen_done; c++) begin
            cyc = c;
            if (restart && c == 60) begin
                start = 1'b1; mode = 3'd1; duty_pct = 7'd10; offset = 10'd100;
                amplitude = 10'd50; lim_lo = 10'd0; lim_hi = 10'd1023;
            end
            if (restart && c == 61) start = 1'b0;
            if (wr_en) begin
                if (first < 0) begin
                    first = c;
                    chk(c <= 32, "R13", "start-to-first-write latency", c, 32);
                end
                if (exp_q.size() == 0) chk(0, "R12", "unexpected write", wr_addr, 0);
                else begin
                    int ew;
                    ew = exp_q.pop_front();
                    chk(wr_addr == 8'(nwr), "R8", "write address", wr_addr, nwr);
                    chk(wr_data == 32'(ew), tag, $sformatf("word at %0d", nwr), wr_data, ew);
                    chk(wr_data[31:16] == 0 && wr_data[5:0] == 0, "R9", "zero bits", wr_data, ew);
                end
                nwr++;
                last_wr = c;
            end
            if (done) begin
                seen_done = 1;
                chk(!wr_en, "R13", "done alongside write", wr_en, 0);
                chk(exp_q.size() == 0, "R13", "writes left at done", exp_q.size(), 0);
                if (m <= 3) begin
                    chk(last_wr == c - 1, "R13", "done not next to last write", last_wr, c - 1);
                    chk(nwr == 129, "R11", "write count", nwr, 129);
                end else chk(nwr == 0, "R12", "write count for inert shape", nwr, 0);
            end
            @(negedge clk);
        end
        if (!seen_done) chk(0, "R13", "done never seen", cyc, 0);
        else begin
            chk(!done && !busy, "R13", "done width or busy release", {done, busy}, 0);
            chk(!wr_en, "R8", "write after done", wr_en, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "reset outputs", {busy, done, wr_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "idle after reset", {busy, done, wr_en}, 0);
        run_case("R3", 0, 50, 800, 512, 0, 1023, 0);
        run_case("R3", 0, 30, 600, 500, 0, 1023, 0);
        run_case("R4", 1, 25, 700, 400, 0, 1023, 0);
        run_case("R5", 2, 50, 900, 512, 0, 1023, 0);
        run_case("R5", 2, 70, 301, 450, 0, 1023, 0);
        run_case("R6", 3, 40, 1000, 512, 0, 1023, 0);
        run_case("R2", 3, 33, 777, 520, 0, 1023, 0);
        run_case("R7", 1, 50, 1000, 600, 200, 900, 0);
        run_case("R7", 0, 60, 1023, 300, 100, 700, 0);
        run_case("R10", 2, 0, 640, 500, 0, 1023, 0);
        run_case("R10", 3, 100, 512, 512, 0, 1023, 0);
        run_case("R10", 0, 127, 400, 600, 0, 1023, 0);
        run_case("R11", 0, 45, 850, 512, 0, 1023, 1);
        run_case("R12", 5, 50, 800, 512, 0, 1023, 0);
        run_case("R12", 7, 20, 100, 300, 0, 1023, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R13 watchdog expired: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule